// File: doc/BRIEF.md
# SPI Slave Shift Interface

This block is the bit-level front end of an SPI target device. The serial clock, the select line and the MOSI data line arrive with no fixed timing relation to the local clock. Each one passes through a two-stage synchroniser, and the serial clock edges are then found by comparing successive synchronised samples. The serial clock idles high. A configuration input picks one of two clock phases: phase 0 samples on the leading (falling) edge, and phase 1 samples on the trailing (rising) edge. Frames are 8 bits long and travel most significant bit first in both directions.

Local logic writes the next reply byte into a holding register ahead of time by pulsing a load strobe. When a frame is received in full, the block delivers the byte together with a one-cycle valid strobe. MISO is driven only while select is active and is high-impedance otherwise. The moment the first reply bit appears depends on the phase. In phase 0 it appears as soon as select is seen active. In phase 1 it appears only at the first falling serial clock edge. The local clock must run at least four times faster than the serial clock.

Top module: `spi_slave_shifter`

## Requirements
- R1: While reset is held and directly after it, rx_valid is 0, miso_oe is 0 and miso_out is high-impedance.
- R2: miso_oe equals the logical select state with a latency of two local clock edges after sel_in changes. miso_out is high-impedance whenever miso_oe is 0.
- R3: With cfg_sel_high = 1, select is active when sel_in is 1. With cfg_sel_high = 0, select is active when sel_in is 0.
- R4: With cfg_cpha = 1, MOSI is sampled on rising serial clock edges, MSB first. rx_valid rises on the third local clock edge after the eighth sampling edge reaches the pin, and rx_byte holds the assembled byte at that point.
- R5: With cfg_cpha = 1, MISO changes on falling serial clock edges. The first bit of a frame is the MSB of the holding register, and it is taken at the frame's first falling edge.
- R6: With cfg_cpha = 0, MOSI is sampled on falling edges and MISO changes on rising edges. The MSB of the holding register is presented as soon as select becomes active.
- R7: With cfg_cpha = 0, every new select assertion restarts the bit count, so each select period carries one fresh frame.
- R8: With cfg_cpha = 1 and select held active, the bit count wraps after 8 bits. Consecutive frames each produce a strobe, and each new frame sends the byte that is in the holding register at its first falling edge.
- R9: If select goes inactive before 8 bits have been sampled, the partial frame is dropped and produces no rx_valid.
- R10: A tx_load pulse copies tx_byte into the holding register. A later pulse before the frame starts replaces the earlier value.
- R11: rx_valid is high for exactly one local clock cycle per completed frame, and rx_byte changes only together with rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpha | input | 1 | Clock phase: 0 samples on falling edges, 1 samples on rising edges |
| cfg_sel_high | input | 1 | Select polarity: 1 means active high |
| sck_in | input | 1 | Serial clock from the controller, idle high |
| sel_in | input | 1 | Select from the controller |
| mosi_in | input | 1 | Serial data from the controller |
| tx_byte | input | 8 | Next reply byte |
| tx_load | input | 1 | Copies tx_byte into the holding register |
| rx_byte | output | 8 | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| miso_out | output | 1 | Serial reply data, high-impedance when not selected |
| miso_oe | output | 1 | High while MISO is driven |

## Verification
The main function is tried four ways. A single phase-1 frame with select active low checks sampling edges and the latency of the strobe. Three back-to-back phase-1 frames under one select assertion check counter wrap and reload at the first falling edge. Phase-0 frames with select active high, each in its own select period, check that the first bit appears on select and that the count restarts. Truncated frames in both phases show whether a partial frame leaks a strobe or corrupts the next one. A reference model in the bench predicts rx_valid, rx_byte and miso_oe for every clock. The master side compares each MISO bit at its own sampling moment, so a mistake in the first-bit launch is told apart from a shift-order mistake.

// File: rtl/spi_slv_pkg.sv
// Package: shared types for the SPI slave shift interface.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_slv_pkg;
    // Clock phase selection: which serial clock edge samples data.
    typedef enum logic {
        PH_LEAD  = 1'b0,   // sample on leading (falling) edge, launch on rising
        PH_TRAIL = 1'b1    // launch on falling edge, sample on rising
    } phase_e;
endpackage

// File: rtl/spi_slv_sync.sv
// Module: multi-stage synchroniser for one asynchronous level signal.
// Assumes: STAGES >= 2; the input changes slower than the local clock.
module spi_slv_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) ff <= {STAGES{RST_VAL}};
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/spi_slv_edge.sv
// Module: edge detector for a synchronised level.
// Assumes: input is already in the local clock domain; IDLE is its rest level.
module spi_slv_edge #(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev;

    // Remember the previous sample so edges can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/spi_slv_shift.sv
// Module: bit counter and shift registers of the SPI slave.
// Assumes: sample and launch events never occur in the same cycle, and
// no serial clock edge coincides with a select assertion.
module spi_slv_shift
    import spi_slv_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  phase_e             phase,
    input  logic               sel_act,
    input  logic               sel_rise,
    input  logic               launch_evt,
    input  logic               sample_evt,
    input  logic               mosi_bit,
    input  logic [FRAME_W-1:0] tx_hold,
    output logic               tx_bit,
    output logic [FRAME_W-1:0] rx_byte,
    output logic               rx_valid
);
    localparam int CNT_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] rx_sr;
    logic [FRAME_W-1:0] tx_sr;
    logic [FRAME_W-1:0] rx_next;

    assign rx_next = {rx_sr[FRAME_W-2:0], mosi_bit};
    assign tx_bit  = tx_sr[FRAME_W-1];

    // Count bits, assemble the received frame and shift the reply out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!sel_act) begin
                bit_cnt <= '0;
            end else if (sel_rise) begin
                bit_cnt <= '0;
                if (phase == PH_LEAD) tx_sr <= tx_hold;
            end else begin
                if (sample_evt) begin
                    rx_sr <= rx_next;
                    if (bit_cnt == LAST) begin
                        bit_cnt  <= '0;
                        rx_byte  <= rx_next;
                        rx_valid <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (launch_evt) begin
                    if (bit_cnt == '0) tx_sr <= tx_hold;
                    else               tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spi_slave_shifter.sv
// Module: SPI slave shift interface top, serial clock idle high.
// Assumes: local clock at least 4x the serial clock; configuration inputs
// change only while select is inactive.
module spi_slave_shifter
    import spi_slv_pkg::*;
#(
    parameter int FRAME_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_cpha,
    input  logic               cfg_sel_high,
    input  logic               sck_in,
    input  logic               sel_in,
    input  logic               mosi_in,
    input  logic [FRAME_W-1:0] tx_byte,
    input  logic               tx_load,
    output logic [FRAME_W-1:0] rx_byte,
    output logic               rx_valid,
    output logic               miso_out,
    output logic               miso_oe
);
    localparam int NSIG = 3;                  // sck, select, mosi
    localparam logic [NSIG-1:0] SYNC_RST = 3'b100;

    logic [NSIG-1:0]    raw_in;
    logic [NSIG-1:0]    syn_out;
    logic               sck_s, sel_act, mosi_s;
    logic               sck_rise, sck_fall, sel_rise, sel_fall_unused;
    logic               launch_evt, sample_evt, tx_bit;
    logic [FRAME_W-1:0] tx_hold;
    phase_e             phase;

    // Select is normalised to active-high before synchronisation.
    assign raw_in = {sck_in, sel_in ~^ cfg_sel_high, mosi_in};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        spi_slv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
            .clk(clk), .rst_n(rst_n), .d(raw_in[g]), .q(syn_out[g])
        );
    end

    assign {sck_s, sel_act, mosi_s} = syn_out;

    spi_slv_edge #(.IDLE(1'b1)) u_sck_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sck_s), .rise(sck_rise), .fall(sck_fall)
    );

    spi_slv_edge #(.IDLE(1'b0)) u_sel_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sel_act), .rise(sel_rise), .fall(sel_fall_unused)
    );

    assign phase      = phase_e'(cfg_cpha);
    assign launch_evt = sel_act & ((phase == PH_TRAIL) ? sck_fall : sck_rise);
    assign sample_evt = sel_act & ((phase == PH_TRAIL) ? sck_rise : sck_fall);

    // Holding register for the next reply byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_hold <= '0;
        else if (tx_load) tx_hold <= tx_byte;
    end

    spi_slv_shift #(.FRAME_W(FRAME_W)) u_core (
        .clk(clk), .rst_n(rst_n), .phase(phase), .sel_act(sel_act),
        .sel_rise(sel_rise), .launch_evt(launch_evt), .sample_evt(sample_evt),
        .mosi_bit(mosi_s), .tx_hold(tx_hold), .tx_bit(tx_bit),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    assign miso_oe  = sel_act;
    assign miso_out = miso_oe ? tx_bit : 1'bz;
endmodule

// File: rtl/spi_slave_shifter_chk.sv
// Module: assertion checker bound to spi_slave_shifter.
// Assumes: serial clock edges at least four local clocks apart.
module spi_slave_shifter_chk #(
    parameter int FRAME_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [FRAME_W-1:0] rx_byte,
    input logic               rx_valid,
    input logic               miso_out,
    input logic               miso_oe,
    input logic               launch_evt,
    input logic               sel_rise
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);                                    // R11

    AST_VALID_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(miso_oe));                               // R9

    AST_RX_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_byte));                            // R11

    AST_MISO_CHANGES_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe) && !$past(launch_evt) && !$past(sel_rise))
        |-> $stable(miso_out));                                     // R5
endmodule

bind spi_slave_shifter spi_slave_shifter_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .miso_out(miso_out), .miso_oe(miso_oe), .launch_evt(launch_evt),
    .sel_rise(sel_rise)
);

// File: tb/test_spi_slave_shifter.sv
// Bench: behavioural master plus per-clock reference model.
module test_spi_slave_shifter;
    localparam int HALF = 4;   // serial half period in local clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpha = 1'b1, cfg_sel_high = 1'b0;
    logic       sck = 1'b1, sel = 1'b0, mosi = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_load = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid, miso_out, miso_oe;
    wire        sel_in = cfg_sel_high ? sel : ~sel;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit mon_on = 1'b0;
    bit ev_now = 1'b0;
    logic [7:0] ev_byte;
    int   mcnt = 0;
    logic [7:0] mbyte = '0;
    logic [7:0] exp_q[$];
    bit   vh[3] = '{0, 0, 0};
    bit   sh[2] = '{0, 0};

    always #2.5 clk = ~clk;

    spi_slave_shifter i_spi_slave_shifter (
        .clk(clk), .rst_n(rst_n), .cfg_cpha(cfg_cpha), .cfg_sel_high(cfg_sel_high),
        .sck_in(sck), .sel_in(sel_in), .mosi_in(mosi), .tx_byte(tx_byte),
        .tx_load(tx_load), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .miso_out(miso_out), .miso_oe(miso_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [7:0] v);   // R10
        tx_byte = v; tx_load = 1'b1;
        tick(1);
        tx_load = 1'b0;
    endtask

    task automatic set_sel(input bit v);
        if (v != sel) mcnt = 0;
        sel = v;
    endtask

    task automatic model_sample(input bit b);
        mbyte = {mbyte[6:0], b};
        mcnt++;
        if (mcnt == 8) begin
            ev_now = 1'b1; ev_byte = mbyte; mcnt = 0;
        end
    endtask

    // Master side of one frame; checks MISO at the master's sampling moment.
    task automatic frame(input logic [7:0] mo, input logic [7:0] ex, input int nbits,
                         input bit do_next, input logic [7:0] nxt);
        for (int i = 7; i > 7 - nbits; i--) begin
            if (cfg_cpha) begin
                sck = 1'b0; mosi = mo[i];
                tick(HALF);
                chk(miso_out === ex[i], "R5 phase1 MISO bit", {7'd0, miso_out}, {7'd0, ex[i]});
                sck = 1'b1; model_sample(mo[i]);
                tick(HALF);
                if (i == 7 && do_next) load(nxt);
            end else begin
                mosi = mo[i];
                tick(HALF);
                chk(miso_out === ex[i], "R6 phase0 MISO bit", {7'd0, miso_out}, {7'd0, ex[i]});
                sck = 1'b0; model_sample(mo[i]);
                tick(HALF);
                sck = 1'b1;
            end
        end
        tick(HALF);
    endtask

    // Reference model compared on every clock (R2, R4, R11).
    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            chk(rx_valid === vh[2], "R11 rx_valid timing", {7'd0, rx_valid}, {7'd0, vh[2]});
            if (vh[2]) begin
                chk(exp_q.size() > 0 && rx_byte === exp_q[0], "R4 rx_byte",
                    rx_byte, exp_q.size() > 0 ? exp_q[0] : 8'hxx);
                if (exp_q.size() > 0) void'(exp_q.pop_front());
            end
            chk(miso_oe === sh[1], "R2 miso_oe", {7'd0, miso_oe}, {7'd0, sh[1]});
            if (!sh[1])
                chk(miso_out === 1'bz, "R2 MISO high-Z", {7'd0, miso_out}, 8'h00);
        end
        vh[2] = vh[1]; vh[1] = vh[0]; vh[0] = ev_now;
        if (ev_now) exp_q.push_back(ev_byte);
        ev_now = 1'b0;
        sh[1] = sh[0]; sh[0] = sel;
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(4);
        // R1: reset state while reset is held
        chk(rx_valid === 1'b0, "R1 rx_valid in reset", {7'd0, rx_valid}, 8'h00);
        chk(miso_oe === 1'b0, "R1 miso_oe in reset", {7'd0, miso_oe}, 8'h00);
        chk(miso_out === 1'bz, "R1 MISO high-Z in reset", {7'd0, miso_out}, 8'h00);
        rst_n = 1'b1;
        mon_on = 1'b1;
        tick(3);

        // R3 active-low select, R4/R5 single phase-1 frame
        load(8'hA5);
        set_sel(1); tick(HALF);
        frame(8'h3C, 8'hA5, 8, 0, 8'h00);
        set_sel(0); tick(2 * HALF);

        // R8 continuous phase-1 frames under one select
        load(8'h11);
        set_sel(1); tick(HALF);
        frame(8'hC3, 8'h11, 8, 1, 8'h22);
        frame(8'h5A, 8'h22, 8, 1, 8'h33);
        frame(8'h0F, 8'h33, 8, 0, 8'h00);
        set_sel(0); tick(2 * HALF);

        // R9 partial phase-1 frame dropped, next frame clean
        load(8'h77);
        set_sel(1); tick(HALF);
        frame(8'hFF, 8'h77, 5, 0, 8'h00);
        set_sel(0); tick(2 * HALF);
        set_sel(1); tick(HALF);
        frame(8'hE1, 8'h77, 8, 0, 8'h00);
        set_sel(0); tick(2 * HALF);

        // R3 active-high select, R6 phase 0, R10 reload replaces
        cfg_cpha = 1'b0; cfg_sel_high = 1'b1;
        tick(4);
        load(8'h12); load(8'h9C);
        set_sel(1); tick(1);
        frame(8'h81, 8'h9C, 8, 0, 8'h00);
        set_sel(0); tick(2 * HALF);
        // R7 new select period restarts the count
        load(8'h6E);
        set_sel(1); tick(1);
        frame(8'h7E, 8'h6E, 8, 0, 8'h00);
        set_sel(0); tick(2 * HALF);

        // R9 with R7: partial phase-0 frame then a fresh one
        load(8'h55);
        set_sel(1); tick(1);
        frame(8'h00, 8'h55, 3, 0, 8'h00);
        set_sel(0); tick(2 * HALF);
        set_sel(1); tick(1);
        frame(8'h99, 8'h55, 8, 0, 8'h00);
        set_sel(0); tick(4 * HALF);

        chk(exp_q.size() == 0, "R9 all expected bytes delivered", 8'(exp_q.size()), 8'h00);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule